// File: doc/BRIEF.md
# Memory Error Injection Unit

This unit sits next to the check-bit path of a memory controller and deliberately corrupts chosen accesses so that error detection and reporting logic can be exercised. Software programs an address pattern made of six fields: DIMM slot within a channel, rank, channel, bank, page and column. Any field can instead be marked "don't care". Software also programs a check-bit mask, a two-bit section selector, an error-type bit set and an arm control.

Each cycle in which the controller completes a request handshake (`txn_valid` and `txn_ready` both high), the unit compares the request's address fields against the pattern. This happens for both reads and writes. When the unit is armed and the request matches, it raises an inject strobe in that same cycle. Depending on the type bits, it XORs the mask into the low half, the high half or both halves of the check bits, and/or signals that parity should be flipped. In one-shot mode the unit disarms itself after the first hit. In repeat mode it corrupts every matching request until software disarms it.

Top module: `mei_inject_unit`

## Requirements
- R1: After reset, all six pattern registers read `0x8000_0000` (wildcard bit 31 set, value 0). The mask, section, type and arm registers read 0.
- R2: Register offsets are:
  - 0 = DIMM, 1 = rank, 2 = channel, 3 = bank, 4 = page, 5 = column.
  - 6 = check mask, in bits [HALF_W-1:0].
  - 7 = section, in bits [1:0].
  - 8 = type, in bits [2:0].
  - 9 = arm, in bit 0.

  A pattern write stores bit 31 as the wildcard flag and the low bits, truncated to the field width, as the value. Every register reads back what was stored. Offset 9 reads the current armed flag. Unmapped offsets read 0.
- R3: A request matches only when every field is either a wildcard or equal to the request's field.
- R4: `inj_strobe` is high only in a handshake cycle (`txn_valid` and `txn_ready` both high) in which the unit is armed, the request matches, and type bit 1 (ECC) or type bit 2 (parity) is set. All outputs are combinational in that same cycle.
- R5: When the strobe is high and type bit 1 is set, `inj_chk` equals `txn_chk` XOR the mask, applied per half:
  - The mask goes into the low half when section bit 0 is set and into the high half when section bit 1 is set. So section 1 = low, 2 = high, 3 = both.
  - `inj_sect` shows the section value during a strobe.
- R6: When the strobe is high and type bit 2 is set, `inj_parity` is high. If type bit 1 is clear, `inj_chk` equals `txn_chk`.
- R7: When type bit 0 (repeat) is clear, the first strobe clears the armed flag. Later matching requests raise no strobe, and offset 9 reads 0.
- R8: When type bit 0 is set, the unit stays armed and strobes on every matching handshake.
- R9: Writing a nonzero value to offset 9 arms the unit, and writing zero disarms it. A write to offset 9 in the same cycle as a strobe sets the armed flag to the written value.
- R10: Without a strobe, `inj_chk` equals `txn_chk`, and `inj_parity` and `inj_sect` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| txn_valid | input | 1 | Request valid |
| txn_ready | input | 1 | Request accepted by the controller |
| txn_dimm | input | DIMM_W | DIMM slot within channel |
| txn_rank | input | RANK_W | Rank |
| txn_chan | input | CH_W | Channel |
| txn_bank | input | BANK_W | Bank |
| txn_page | input | PAGE_W | Page (row) |
| txn_col | input | COL_W | Column |
| txn_chk | input | 2*HALF_W | Check bits from the ECC encoder |
| inj_strobe | output | 1 | Injection happens this cycle |
| inj_chk | output | 2*HALF_W | Check bits after corruption |
| inj_parity | output | 1 | Flip parity for this request |
| inj_sect | output | 2 | Sections hit during a strobe |

## Verification
The armed flag is the only state that changes without a register write, so most internal faults show up as a wrong strobe decision. A flag left set after a one-shot hit shows on the very next matching handshake as an extra strobe. The same fault also shows on the offset-9 readback. A wrong pattern or wildcard bit appears in the first request that differs in only that field. A wrong section decode shows in the same cycle as a corrupted half of `inj_chk`.

// File: rtl/mei_pkg.sv
package mei_pkg;

   localparam int NFIELD  = 6;
   localparam int VAL_W   = 31;
   localparam int REG_W   = 32;
   localparam int ANY_BIT = 31;

   typedef enum logic [3:0] {
      OFS_DIMM  = 4'd0,
      OFS_RANK  = 4'd1,
      OFS_CHAN  = 4'd2,
      OFS_BANK  = 4'd3,
      OFS_PAGE  = 4'd4,
      OFS_COL   = 4'd5,
      OFS_MASK  = 4'd6,
      OFS_SECT  = 4'd7,
      OFS_TYPE  = 4'd8,
      OFS_ARM   = 4'd9
   } mei_ofs_e;

   localparam int TYP_REPEAT = 0;
   localparam int TYP_ECC    = 1;
   localparam int TYP_PARITY = 2;

   function automatic logic [VAL_W-1:0] width_mask(input int w);
      logic [63:0] m;
      m = (64'd1 << w) - 64'd1;
      return m[VAL_W-1:0];
   endfunction

endpackage

// File: rtl/mei_cfg_regs.sv
module mei_cfg_regs
   import mei_pkg::*;
#(
   parameter int DIMM_W = 2,
   parameter int RANK_W = 2,
   parameter int CH_W   = 2,
   parameter int BANK_W = 3,
   parameter int PAGE_W = 16,
   parameter int COL_W  = 11,
   parameter int HALF_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [3:0]                   cfg_addr,
   input  logic [REG_W-1:0]             cfg_wdata,
   output logic [REG_W-1:0]             cfg_rdata,
   input  logic                         armed,
   output logic [NFIELD-1:0][VAL_W-1:0] pat_val,
   output logic [NFIELD-1:0]            pat_any,
   output logic [HALF_W-1:0]            ecc_mask,
   output logic [1:0]                   sect,
   output logic [2:0]                   typ,
   output logic                         arm_wr,
   output logic                         arm_val
);

   function automatic int field_w(input int i);
      case (i)
         0: return DIMM_W;
         1: return RANK_W;
         2: return CH_W;
         3: return BANK_W;
         4: return PAGE_W;
         default: return COL_W;
      endcase
   endfunction

   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      localparam logic [VAL_W-1:0] FMASK = width_mask(field_w(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pat_val[i] <= '0;
            pat_any[i] <= 1'b1;
         end else if (cfg_we && cfg_addr == 4'(i)) begin
            pat_val[i] <= cfg_wdata[VAL_W-1:0] & FMASK;
            pat_any[i] <= cfg_wdata[ANY_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ecc_mask <= '0;
         sect     <= '0;
         typ      <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            OFS_MASK: ecc_mask <= cfg_wdata[HALF_W-1:0];
            OFS_SECT: sect     <= cfg_wdata[1:0];
            OFS_TYPE: typ      <= cfg_wdata[2:0];
            default: ;
         endcase
      end
   end

   assign arm_wr  = cfg_we && (cfg_addr == OFS_ARM);
   assign arm_val = |cfg_wdata;

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr < 4'(NFIELD)) begin
         cfg_rdata = {pat_any[cfg_addr[2:0]], pat_val[cfg_addr[2:0]]};
      end else begin
         case (cfg_addr)
            OFS_MASK: cfg_rdata = REG_W'(ecc_mask);
            OFS_SECT: cfg_rdata = REG_W'(sect);
            OFS_TYPE: cfg_rdata = REG_W'(typ);
            OFS_ARM:  cfg_rdata = REG_W'(armed);
            default:  cfg_rdata = '0;
         endcase
      end
   end

   // R1: one cycle after reset, every pattern field is a wildcard
   a_r1_reset_wild: assert property (@(posedge clk)
      !rst_n |=> (&pat_any) && (sect == 2'b00) && (typ == 3'b000));

   // R2: a pattern write lands in the addressed field on the next edge
   a_r2_field_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == OFS_DIMM) |=> (pat_any[0] == $past(cfg_wdata[ANY_BIT])));

endmodule

// File: rtl/mei_addr_match.sv
module mei_addr_match
   import mei_pkg::*;
(
   input  logic [NFIELD-1:0][VAL_W-1:0] pat_val,
   input  logic [NFIELD-1:0]            pat_any,
   input  logic [NFIELD-1:0][VAL_W-1:0] key,
   output logic                         match
);

   logic [NFIELD-1:0] hit;

   for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
      assign hit[i] = pat_any[i] || (pat_val[i] == key[i]);
   end

   assign match = &hit;

   // R3: a match can never coexist with a specific field that differs
   always_comb begin
      for (int i = 0; i < NFIELD; i++) begin
         a_r3_field_agree: assert (!(match && !pat_any[i] && pat_val[i] != key[i]));
      end
   end

endmodule

// File: rtl/mei_fire_ctrl.sv
module mei_fire_ctrl
   import mei_pkg::*;
#(
   parameter int HALF_W   = 8,
   parameter int SECTIONS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hs,
   input  logic                       match,
   input  logic [2:0]                 typ,
   input  logic [1:0]                 sect,
   input  logic [HALF_W-1:0]          ecc_mask,
   input  logic [SECTIONS*HALF_W-1:0] chk_in,
   input  logic                       arm_wr,
   input  logic                       arm_val,
   output logic                       strobe,
   output logic [SECTIONS*HALF_W-1:0] chk_out,
   output logic                       parity,
   output logic [1:0]                 sect_out,
   output logic                       armed
);

   logic want;
   assign want   = typ[TYP_ECC] | typ[TYP_PARITY];
   assign strobe = armed & hs & match & want;

   for (genvar h = 0; h < SECTIONS; h++) begin : g_half
      logic flip;
      assign flip = strobe & typ[TYP_ECC] & sect[h];
      assign chk_out[h*HALF_W +: HALF_W] =
         chk_in[h*HALF_W +: HALF_W] ^ (flip ? ecc_mask : '0);
   end

   assign parity   = strobe & typ[TYP_PARITY];
   assign sect_out = strobe ? sect : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (arm_wr) begin
         armed <= arm_val;
      end else if (strobe && !typ[TYP_REPEAT]) begin
         armed <= 1'b0;
      end
   end

   // R4: a strobe needs a completed handshake
   a_r4_strobe_hs: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> hs);

   // R7: one-shot hit disarms
   a_r7_once_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !typ[TYP_REPEAT] && !arm_wr) |=> !armed);

   // R8: repeat hit stays armed
   a_r8_repeat_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && typ[TYP_REPEAT] && !arm_wr) |=> armed);

   // R9: an arm write sets the flag to the written value
   a_r9_arm_write: assert property (@(posedge clk) disable iff (!rst_n)
      arm_wr |=> (armed == $past(arm_val)));

   // R10: quiet outputs without a strobe
   a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> (chk_out == chk_in) && !parity && (sect_out == 2'b00));

endmodule

// File: rtl/mei_inject_unit.sv
module mei_inject_unit
   import mei_pkg::*;
#(
   parameter int NUM_CH       = 3,
   parameter int DIMMS_PER_CH = 3,
   parameter int DIMM_W       = 2,
   parameter int RANK_W       = 2,
   parameter int CH_W         = 2,
   parameter int BANK_W       = 3,
   parameter int PAGE_W       = 16,
   parameter int COL_W        = 11,
   parameter int HALF_W       = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [3:0]            cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic                  txn_valid,
   input  logic                  txn_ready,
   input  logic [DIMM_W-1:0]     txn_dimm,
   input  logic [RANK_W-1:0]     txn_rank,
   input  logic [CH_W-1:0]       txn_chan,
   input  logic [BANK_W-1:0]     txn_bank,
   input  logic [PAGE_W-1:0]     txn_page,
   input  logic [COL_W-1:0]      txn_col,
   input  logic [2*HALF_W-1:0]   txn_chk,
   output logic                  inj_strobe,
   output logic [2*HALF_W-1:0]   inj_chk,
   output logic                  inj_parity,
   output logic [1:0]            inj_sect
);

   localparam int SECTIONS = 2;

   if (DIMM_W < 1 || RANK_W < 1 || CH_W < 1 || BANK_W < 1 ||
       PAGE_W < 1 || COL_W < 1) begin : g_bad_min
      $error("mei_inject_unit: every field width must be at least 1");
   end
   if (DIMM_W > VAL_W || RANK_W > VAL_W || CH_W > VAL_W || BANK_W > VAL_W ||
       PAGE_W > VAL_W || COL_W > VAL_W) begin : g_bad_max
      $error("mei_inject_unit: a field width exceeds the register value span");
   end
   if ((1 << CH_W) < NUM_CH || (1 << DIMM_W) < DIMMS_PER_CH) begin : g_bad_range
      $error("mei_inject_unit: channel or DIMM field too narrow");
   end
   if (HALF_W < 1 || HALF_W > REG_W) begin : g_bad_half
      $error("mei_inject_unit: HALF_W out of range");
   end

   logic [NFIELD-1:0][VAL_W-1:0] pat_val;
   logic [NFIELD-1:0]            pat_any;
   logic [NFIELD-1:0][VAL_W-1:0] key;
   logic [HALF_W-1:0]            ecc_mask;
   logic [1:0]                   sect;
   logic [2:0]                   typ;
   logic                         arm_wr, arm_val, armed, match;

   assign key[0] = VAL_W'(txn_dimm);
   assign key[1] = VAL_W'(txn_rank);
   assign key[2] = VAL_W'(txn_chan);
   assign key[3] = VAL_W'(txn_bank);
   assign key[4] = VAL_W'(txn_page);
   assign key[5] = VAL_W'(txn_col);

   mei_cfg_regs #(
      .DIMM_W(DIMM_W), .RANK_W(RANK_W), .CH_W(CH_W), .BANK_W(BANK_W),
      .PAGE_W(PAGE_W), .COL_W(COL_W), .HALF_W(HALF_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .armed(armed),
      .pat_val(pat_val), .pat_any(pat_any), .ecc_mask(ecc_mask),
      .sect(sect), .typ(typ), .arm_wr(arm_wr), .arm_val(arm_val)
   );

   mei_addr_match u_match (
      .pat_val(pat_val), .pat_any(pat_any), .key(key), .match(match)
   );

   mei_fire_ctrl #(.HALF_W(HALF_W), .SECTIONS(SECTIONS)) u_fire (
      .clk(clk), .rst_n(rst_n), .hs(txn_valid & txn_ready), .match(match),
      .typ(typ), .sect(sect), .ecc_mask(ecc_mask), .chk_in(txn_chk),
      .arm_wr(arm_wr), .arm_val(arm_val), .strobe(inj_strobe),
      .chk_out(inj_chk), .parity(inj_parity), .sect_out(inj_sect),
      .armed(armed)
   );

   // R5: section output only ever names a programmed section during a strobe
   a_r5_sect_follow: assert property (@(posedge clk) disable iff (!rst_n)
      inj_strobe |-> (inj_sect == sect));

   // R6: parity flip only accompanies a strobe
   a_r6_parity_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      inj_parity |-> inj_strobe);

endmodule

// File: tb/mei_inject_unit_bench.sv
module mei_inject_unit_bench;

   localparam int DIMM_W = 2, RANK_W = 2, CH_W = 2, BANK_W = 3;
   localparam int PAGE_W = 16, COL_W = 11, HALF_W = 8;
   localparam int CW = 2 * HALF_W;
   localparam int EW = 1 + CW + 1 + 2;

   logic clk = 0;
   logic rst_n = 0;
   always #10 clk = ~clk;

   logic              cfg_we = 0;
   logic [3:0]        cfg_addr = 0;
   logic [31:0]       cfg_wdata = 0;
   logic [31:0]       cfg_rdata;
   logic              txn_valid = 0, txn_ready = 0;
   logic [DIMM_W-1:0] txn_dimm = 0;
   logic [RANK_W-1:0] txn_rank = 0;
   logic [CH_W-1:0]   txn_chan = 0;
   logic [BANK_W-1:0] txn_bank = 0;
   logic [PAGE_W-1:0] txn_page = 0;
   logic [COL_W-1:0]  txn_col = 0;
   logic [CW-1:0]     txn_chk = 0;
   logic              inj_strobe, inj_parity;
   logic [CW-1:0]     inj_chk;
   logic [1:0]        inj_sect;

   mei_inject_unit u_mei_inject_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
      .txn_ready(txn_ready), .txn_dimm(txn_dimm), .txn_rank(txn_rank),
      .txn_chan(txn_chan), .txn_bank(txn_bank), .txn_page(txn_page),
      .txn_col(txn_col), .txn_chk(txn_chk), .inj_strobe(inj_strobe),
      .inj_chk(inj_chk), .inj_parity(inj_parity), .inj_sect(inj_sect)
   );

   int n_cmp = 0, n_bad = 0;

   // model state, derived from the requirements
   logic [30:0]       m_val [6];
   logic              m_any [6];
   logic [HALF_W-1:0] m_mask;
   logic [1:0]        m_sect;
   logic [2:0]        m_typ;
   logic              m_armed;

   logic [EW-1:0] exp_q [$];
   string         tag_q [$];

   function automatic logic [30:0] fmask(input int i);
      int w;
      case (i)
         0: w = DIMM_W; 1: w = RANK_W; 2: w = CH_W;
         3: w = BANK_W; 4: w = PAGE_W; default: w = COL_W;
      endcase
      return 31'((64'd1 << w) - 64'd1);
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 6; i++) begin m_val[i] = '0; m_any[i] = 1'b1; end
      m_mask = '0; m_sect = '0; m_typ = '0; m_armed = 1'b0;
   endtask

   task automatic model_write(input logic [3:0] a, input logic [31:0] d);
      if (a < 6) begin
         m_val[a] = d[30:0] & fmask(int'(a));
         m_any[a] = d[31];
      end else if (a == 6) m_mask = d[HALF_W-1:0];
      else if (a == 7) m_sect = d[1:0];
      else if (a == 8) m_typ = d[2:0];
      else if (a == 9) m_armed = |d;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      model_write(a, d);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #5;
      check(tag, cfg_rdata, exp);
   endtask

   // driver: one request cycle, optionally with a same-cycle arm write
   task automatic send(input string tag, input logic rdy,
                       input int dimm, input int rank, input int chan,
                       input int bank, input int page, input int col,
                       input logic [CW-1:0] chk,
                       input logic arm_too, input logic [31:0] arm_d);
      logic [30:0] key [6];
      logic hit, strobe;
      logic [CW-1:0] c;
      @(negedge clk);
      txn_valid = 1; txn_ready = rdy;
      txn_dimm = DIMM_W'(dimm); txn_rank = RANK_W'(rank);
      txn_chan = CH_W'(chan);   txn_bank = BANK_W'(bank);
      txn_page = PAGE_W'(page); txn_col = COL_W'(col);
      txn_chk = chk;
      if (arm_too) begin cfg_we = 1; cfg_addr = 4'd9; cfg_wdata = arm_d; end
      key[0] = 31'(txn_dimm); key[1] = 31'(txn_rank); key[2] = 31'(txn_chan);
      key[3] = 31'(txn_bank); key[4] = 31'(txn_page); key[5] = 31'(txn_col);
      hit = 1'b1;
      for (int i = 0; i < 6; i++) if (!m_any[i] && m_val[i] != key[i]) hit = 1'b0;
      strobe = m_armed && rdy && hit && (m_typ[1] || m_typ[2]);
      c = chk;
      if (strobe && m_typ[1]) begin
         if (m_sect[0]) c[HALF_W-1:0]    = c[HALF_W-1:0] ^ m_mask;
         if (m_sect[1]) c[CW-1:HALF_W]   = c[CW-1:HALF_W] ^ m_mask;
      end
      exp_q.push_back({strobe, c, strobe && m_typ[2], strobe ? m_sect : 2'b00});
      tag_q.push_back(tag);
      if (arm_too) m_armed = |arm_d;
      else if (strobe && !m_typ[0]) m_armed = 1'b0;
      @(negedge clk);
      txn_valid = 0; txn_ready = 0;
      if (arm_too) cfg_we = 0;
   endtask

   // monitor: compares every driven request cycle against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (txn_valid) begin
            logic [EW-1:0] e;
            string t;
            if (exp_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL scoreboard: got 0x%0h expected none",
                        {inj_strobe, inj_chk, inj_parity, inj_sect});
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, 32'({inj_strobe, inj_chk, inj_parity, inj_sect}), 32'(e));
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      for (int i = 0; i < 6; i++) rd(4'(i), 32'h8000_0000, "R1 pattern reset");
      rd(4'd6, 0, "R1 mask reset");
      rd(4'd9, 0, "R1 arm reset");

      // R2 write and readback, truncation, unmapped
      wr(4'd0, 32'h0000_0002);
      rd(4'd0, 32'h0000_0002, "R2 dimm readback");
      wr(4'd1, 32'h8000_0007);
      rd(4'd1, 32'h8000_0003, "R2 rank truncated");
      wr(4'd1, 32'h8000_0000);
      rd(4'd12, 0, "R2 unmapped");

      // one-shot ECC on both halves
      wr(4'd8, 32'd2); wr(4'd6, 32'h40); wr(4'd7, 32'd3);
      rd(4'd7, 32'd3, "R2 section readback");
      wr(4'd9, 32'd1);
      rd(4'd9, 32'd1, "R9 armed readback");
      send("R3 dimm mismatch",  1, 1, 0, 0, 0, 0, 0, 16'h1234, 0, 0);
      send("R4 no ready",       0, 2, 0, 0, 0, 0, 0, 16'h1234, 0, 0);
      send("R5 both halves",    1, 2, 1, 2, 3, 100, 7, 16'h1234, 0, 0);
      send("R7 once no refire", 1, 2, 0, 0, 0, 0, 0, 16'h1234, 0, 0);
      rd(4'd9, 0, "R7 disarmed readback");

      // repeat mode, low then high section
      wr(4'd7, 32'd1); wr(4'd8, 32'd3); wr(4'd6, 32'h81); wr(4'd9, 32'h500);
      send("R8 repeat first",  1, 2, 0, 1, 0, 0, 0, 16'hA5A5, 0, 0);
      send("R8 repeat second", 1, 2, 3, 0, 7, 9, 1, 16'h0F0F, 0, 0);
      wr(4'd7, 32'd2);
      send("R5 high half",     1, 2, 0, 0, 0, 0, 0, 16'h00FF, 0, 0);
      rd(4'd9, 1, "R8 still armed");

      // parity only
      wr(4'd8, 32'd4);
      send("R6 parity only",   1, 2, 0, 0, 0, 0, 0, 16'hBEEF, 0, 0);

      // disarm
      wr(4'd9, 32'd0);
      send("R9 disarmed",      1, 2, 0, 0, 0, 0, 0, 16'hBEEF, 0, 0);

      // armed but no error kind
      wr(4'd8, 32'd1); wr(4'd9, 32'd1);
      send("R4 no kind",       1, 2, 0, 0, 0, 0, 0, 16'h1111, 0, 0);

      // arm write in the same cycle as a one-shot strobe
      wr(4'd8, 32'd2); wr(4'd7, 32'd3);
      send("R9 same-cycle fire", 1, 2, 0, 0, 0, 0, 0, 16'h2222, 1, 32'd1);
      rd(4'd9, 1, "R9 write wins");
      send("R9 fires again",   1, 2, 0, 0, 0, 0, 0, 16'h3333, 0, 0);

      // other fields: channel and bank
      wr(4'd0, 32'h8000_0000); wr(4'd2, 32'd2); wr(4'd3, 32'd5);
      wr(4'd8, 32'd3); wr(4'd9, 32'd1);
      send("R3 chan mismatch", 1, 0, 0, 1, 5, 0, 0, 16'h4444, 0, 0);
      send("R3 bank mismatch", 1, 0, 0, 2, 4, 0, 0, 16'h4444, 0, 0);
      send("R3 chan bank hit", 1, 3, 1, 2, 5, 77, 5, 16'h4444, 0, 0);
      send("R10 idle pass",    0, 3, 1, 2, 5, 77, 5, 16'h5555, 0, 0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check("scoreboard drain", 32'(exp_q.size()), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule